// File: doc/BRIEF.md
# Interrupt Trigger Store Generator

This block sits at the edge of a bridge that owns a set of interrupt sources. It turns each interrupt event into exactly one 8-byte memory write aimed at an interrupt controller. Each event carries a source number and a flag. The flag says that the source has already evaluated its own state bits. Three configuration registers are loaded through a small register port: a control register, a notify address and a notify index.

The block has two modes. In the legacy mode it always writes to the notify address, and the source number is folded into the data word. In the address-based mode the source number selects the target address instead. Each source owns a pair of management pages, and the store goes to the second page of its pair. The page size is chosen by a bit in the notify address, and the data written is zero.

Events are taken through a valid/ready handshake, and only while the block is idle. The write is presented as a held request and then waits for a response. A failed response is flagged for one cycle, and the trigger is dropped with no retry.

Top module: `trig_store_gen`

## Requirements
- R1: After reset, `evtReady` is 1, `wrValid` is 0 and `trigErr` is 0.
- R2: `evtReady` is 1 only while no trigger is in flight. An event accepted on a clock edge (`evtValid` and `evtReady` both 1) makes `wrValid` 1 after that edge.
- R3: While `wrValid` is 1 and `wrReady` is 0, `wrValid`, `wrAddr` and `wrData` hold their values.
- R4: After the write is accepted, the block issues no new request and keeps `evtReady` at 0 until `rspValid` arrives. In the cycle after the response, `evtReady` is 1 again.
- R5: With control bit 53 (LSB-first numbering) clear, the block is in legacy mode. `wrAddr` equals the notify address register unchanged, and `wrData` equals the notify index register OR the zero-extended source number.
- R6: In legacy mode, a checked event also sets data bit `LEG_FLAG_BIT` (default 31, LSB-first) in `wrData`.
- R7: With control bit 53 set, the block is in address-based mode. If notify address bit 62 is clear, then `wrAddr = base | (src << 13) | (1 << 12)`, and `wrData` is 0.
- R8: In address-based mode with notify address bit 62 set, `wrAddr = base | (src << 17) | (1 << 16)`. In both page sizes, `base` is the notify address with bit 62 cleared.
- R9: In address-based mode, a checked event ORs `INJECT_OFS` (default 0x800) into `wrAddr`.
- R10: A response with `rspErr` set makes `trigErr` 1 in that cycle only. The block then goes idle with no retried request.
- R11: Configuration writes made while a trigger is in flight do not change the held request. They apply from the next accepted event.
- R12: On `cfgSel`, 0 selects control, 1 the notify address and 2 the notify index. A write with `cfgSel` = 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 control, 1 notify address, 2 notify index |
| cfgWdata | input | 64 | Configuration write data |
| evtValid | input | 1 | Interrupt event valid |
| evtReady | output | 1 | Block idle and able to take an event |
| evtSrc | input | SRC_W | Source number |
| evtChecked | input | 1 | Source already evaluated its state bits |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write request accepted |
| wrAddr | output | 64 | Write target address |
| wrData | output | 64 | Write data; bit 63 is the first byte sent (big-endian) |
| rspValid | input | 1 | Write response valid |
| rspErr | input | 1 | Write response reports failure |
| trigErr | output | 1 | One-cycle pulse on a failed trigger |

## Verification
The bench builds the block with its default parameters: a 24-bit source number, an inject offset of 0x800 and the legacy flag at data bit 31. With these values, the largest source number in the 64 KiB page mode shifts up to bit 40. That lets the bench confirm that no source bit collides with the page-size bit or with the inject offset. The default flag position sits above every source bit, so a checked legacy event shows up as a distinct data bit.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } trigState_t;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  // bit positions (LSB-first) decoded by the interrupt controller side
  localparam int ABT_MODE_BIT = 53;
  localparam int PAGE64_BIT   = 62;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_INDEX = 2'd2;
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  output logic        evtReady,
  output logic        wrValid,
  input  logic        wrReady,
  input  logic        rspValid,
  input  logic        rspErr,
  output logic        trigErr,
  output ctrlStrobe_t strobe
);
  trigState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (evtValid) stateD = ST_REQ;
      ST_REQ:  if (wrReady)  stateD = ST_RSP;
      ST_RSP:  if (rspValid) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign evtReady    = (stateQ == ST_IDLE);
  assign wrValid     = (stateQ == ST_REQ);
  assign trigErr     = (stateQ == ST_RSP) && rspValid && rspErr;
  assign strobe.load = evtValid && evtReady;

  // R2
  accept_to_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtReady) |=> (wrValid && !evtReady));

  // R4
  wait_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> (!wrValid && !evtReady));

  // R10
  err_no_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigErr |=> (evtReady && !wrValid && !trigErr));
endmodule

// File: rtl/trig_dpath.sv
module trig_dpath
  import trig_pkg::*;
#(
  parameter int          SRC_W        = 24,
  parameter logic [63:0] INJECT_OFS   = 64'h800,
  parameter int          LEG_FLAG_BIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [63:0]       cfgWdata,
  input  logic [SRC_W-1:0]  evtSrc,
  input  logic              evtChecked,
  input  ctrlStrobe_t       strobe,
  output logic [63:0]       reqAddr,
  output logic [63:0]       reqData
);
  localparam logic [63:0] PAGE_MASK = 64'd1 << PAGE64_BIT;
  localparam logic [63:0] FLAG_MASK = 64'd1 << LEG_FLAG_BIT;

  logic        abtMode;
  logic [63:0] notifyAddr;
  logic [63:0] notifyIndex;
  logic [4:0]  pageShift;
  logic [63:0] srcExt;
  logic [63:0] nextAddr;
  logic [63:0] nextData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      abtMode     <= 1'b0;
      notifyAddr  <= '0;
      notifyIndex <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_CTRL:  abtMode     <= cfgWdata[ABT_MODE_BIT];
        SEL_ADDR:  notifyAddr  <= cfgWdata;
        SEL_INDEX: notifyIndex <= cfgWdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    srcExt    = 64'(evtSrc);
    pageShift = notifyAddr[PAGE64_BIT] ? 5'd16 : 5'd12;
    if (abtMode) begin
      nextAddr = (notifyAddr & ~PAGE_MASK)
               | (srcExt << (pageShift + 5'd1))
               | (64'd1 << pageShift)
               | (evtChecked ? INJECT_OFS : 64'd0);
      nextData = '0;
    end else begin
      nextAddr = notifyAddr;
      nextData = notifyIndex | srcExt | (evtChecked ? FLAG_MASK : 64'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr <= '0;
      reqData <= '0;
    end else if (strobe.load) begin
      reqAddr <= nextAddr;
      reqData <= nextData;
    end
  end

  // R7
  abt_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && abtMode) |=> (reqData == 64'd0));

  // R5
  leg_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !abtMode) |=> (reqAddr == $past(notifyAddr)));
endmodule

// File: rtl/trig_store_gen.sv
module trig_store_gen
  import trig_pkg::*;
#(
  parameter int          SRC_W        = 24,
  parameter logic [63:0] INJECT_OFS   = 64'h800,
  parameter int          LEG_FLAG_BIT = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [63:0]      cfgWdata,
  input  logic             evtValid,
  output logic             evtReady,
  input  logic [SRC_W-1:0] evtSrc,
  input  logic             evtChecked,
  output logic             wrValid,
  input  logic             wrReady,
  output logic [63:0]      wrAddr,
  output logic [63:0]      wrData,
  input  logic             rspValid,
  input  logic             rspErr,
  output logic             trigErr
);
  ctrlStrobe_t strobe;

  trig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
    .wrValid(wrValid), .wrReady(wrReady), .rspValid(rspValid),
    .rspErr(rspErr), .trigErr(trigErr), .strobe(strobe)
  );

  trig_dpath #(
    .SRC_W(SRC_W), .INJECT_OFS(INJECT_OFS), .LEG_FLAG_BIT(LEG_FLAG_BIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .evtSrc(evtSrc), .evtChecked(evtChecked),
    .strobe(strobe), .reqAddr(wrAddr), .reqData(wrData)
  );

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));
endmodule

// File: tb/trig_store_gen_tb.sv
`timescale 1ns/1ps
module trig_store_gen_tb;
  localparam int SRC_W = 24;

  typedef struct {
    logic [63:0] addr;
    logic [63:0] data;
    int          hold;
    logic        err;
    string       tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [63:0] cfgWdata = '0;
  logic evtValid = 1'b0;
  logic evtReady;
  logic [SRC_W-1:0] evtSrc = '0;
  logic evtChecked = 1'b0;
  logic wrValid;
  logic wrReady = 1'b0;
  logic [63:0] wrAddr, wrData;
  logic rspValid = 1'b0;
  logic rspErr = 1'b0;
  logic trigErr;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  logic        mAbt = 1'b0;
  logic [63:0] mAddr = '0;
  logic [63:0] mIdx = '0;

  always #2 clk = ~clk;

  trig_store_gen u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .evtValid(evtValid), .evtReady(evtReady), .evtSrc(evtSrc),
    .evtChecked(evtChecked), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .rspValid(rspValid), .rspErr(rspErr),
    .trigErr(trigErr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [63:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0;
    case (sel)
      2'd0: mAbt = val[53];
      2'd1: mAddr = val;
      2'd2: mIdx = val;
      default: ;
    endcase
  endtask

  task automatic sendEvt(input logic [SRC_W-1:0] src, input logic chk,
                         input int hold, input logic err, input string tag);
    expItem_t e;
    logic [63:0] base;
    int sh;
    if (mAbt) begin
      sh = mAddr[62] ? 16 : 12;
      base = mAddr & ~(64'd1 << 62);
      e.addr = base | (64'(src) << (sh + 1)) | (64'd1 << sh) | (chk ? 64'h800 : 64'd0);
      e.data = '0;
    end else begin
      e.addr = mAddr;
      e.data = mIdx | 64'(src) | (chk ? (64'd1 << 31) : 64'd0);
    end
    e.hold = hold; e.err = err; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    while (!evtReady) @(negedge clk);
    evtValid = 1'b1; evtSrc = src; evtChecked = chk;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  // monitor / responder
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (wrValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected request", wrAddr, 64'd0);
        end else begin
          e = expQ.pop_front();
          for (int i = 0; i < e.hold; i++) begin
            check(!evtReady, "R2 ready while busy", 64'(evtReady), 64'd0);
            check(wrValid && wrAddr == e.addr, "R3 hold addr", wrAddr, e.addr);
            @(negedge clk);
          end
          check(wrAddr == e.addr, {e.tag, " addr"}, wrAddr, e.addr);
          check(wrData == e.data, {e.tag, " data"}, wrData, e.data);
          wrReady = 1'b1;
          @(negedge clk);
          wrReady = 1'b0;
          check(!wrValid && !evtReady, "R4 waiting for response",
                64'({wrValid, evtReady}), 64'd0);
          @(negedge clk);
          check(!wrValid && !evtReady, "R4 still waiting",
                64'({wrValid, evtReady}), 64'd0);
          rspValid = 1'b1; rspErr = e.err;
          #1;
          check(trigErr == e.err, "R10 error pulse", 64'(trigErr), 64'(e.err));
          @(negedge clk);
          rspValid = 1'b0; rspErr = 1'b0;
          #1;
          check(evtReady && !wrValid && !trigErr, "R4 R10 idle after response",
                64'({evtReady, wrValid, trigErr}), 64'b100);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(evtReady && !wrValid && !trigErr, "R1 reset state",
          64'({evtReady, wrValid, trigErr}), 64'b100);
    rstN = 1'b1;

    // legacy mode R5 R6
    cfgWrite(2'd1, 64'h0000_1234_5678_0000);
    cfgWrite(2'd2, 64'h0000_0000_00A0_0000);
    sendEvt(24'h000015, 1'b0, 0, 1'b0, "R5 legacy");
    sendEvt(24'h00C0DE, 1'b1, 2, 1'b0, "R6 legacy checked");

    // address-based 4K R7
    cfgWrite(2'd0, 64'd1 << 53);
    cfgWrite(2'd1, 64'h0006_0000_0000_0000);
    sendEvt(24'h000003, 1'b0, 1, 1'b0, "R7 abt 4k");

    // address-based 64K R8, inject R9
    cfgWrite(2'd1, 64'h4006_0000_0000_0000);
    sendEvt(24'h000010, 1'b0, 0, 1'b0, "R8 abt 64k");
    sendEvt(24'hFFFFFF, 1'b0, 3, 1'b0, "R8 abt 64k max src");
    sendEvt(24'h000021, 1'b1, 0, 1'b0, "R9 abt 64k inject");
    cfgWrite(2'd1, 64'h0006_0000_0000_0000);
    sendEvt(24'h000021, 1'b1, 1, 1'b0, "R9 abt 4k inject");

    // failed store R10
    sendEvt(24'h000007, 1'b0, 0, 1'b1, "R10 failed store");

    // in-flight config change R11
    sendEvt(24'h000005, 1'b0, 5, 1'b0, "R11 in-flight abt");
    cfgWrite(2'd0, 64'd0);
    sendEvt(24'h000005, 1'b0, 0, 1'b0, "R11 next legacy");

    // ignored select R12
    cfgWrite(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    sendEvt(24'h000009, 1'b0, 0, 1'b0, "R12 sel3 ignored legacy");
    cfgWrite(2'd0, 64'd1 << 53);
    cfgWrite(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    sendEvt(24'h000009, 1'b0, 0, 1'b0, "R12 sel3 ignored abt");

    while (expQ.size() != 0 || !evtReady || wrValid) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule